// File: doc/BRIEF.md
# Three-line GPIO port with direction control

This block is a small general-purpose I/O port serving three lines, programmed over a simple byte-wide register bus. Each line is either an input or an output, chosen by one bit of a direction register. Output lines drive their pins from an output latch. Input pins pass through a two-flop synchronizer into a sampled-input register. Input activity never raises an interrupt.

A read of the input register combines two sources. It returns the synchronized pin levels ORed with the latch bits of the lines currently set as outputs, so software sees what an output line is driving even while the pin itself reads low. A one-cycle change pulse per line reports every change in what a line drives. The pulse fires when software flips the line's direction, or when it rewrites the latch bit of a line that is an output.

Top module: `gpio3_port`

## Requirements
- R1: After reset, the direction register reads 0x07 (all three lines are inputs), the output latch reads 0x00, `pin_oe` and `pin_out` are 0, and `drive_chg` is 0.
- R2: A write to address 0 (direction) stores the write data ANDed with 0x67. Reading address 0 returns that stored byte.
- R3: A write to address 2 (output latch) stores only data bits 2:0. Reading address 2 returns those bits with bits 7:3 at zero.
- R4: For each line i, `pin_oe[i]` is the inverse of direction bit i, and `pin_out[i]` is latch bit i. A direction bit of 1 means input.
- R5: Reading address 1 (input) returns, in bits 2:0, the sampled pin levels ORed with the latch bits of lines whose direction bit is 0. Bits 7:3 read as zero.
- R6: A change on `pin_in` shows up at address 1 after exactly two rising clock edges, and not after only one.
- R7: Changes on `pin_in` alone never assert `drive_chg`.
- R8: In the cycle after a latch write, `drive_chg[i]` is 1 exactly for the lines whose direction bit is 0 and whose latch bit changed.
- R9: In the cycle after a direction write, `drive_chg[i]` is 1 exactly for the lines whose direction bit (bits 2:0) changed.
- R10: Writes to address 1 and address 3 change neither the direction register nor the latch. A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 2 | Register address: 0 direction, 1 input, 2 output latch |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 3 | Asynchronous pin levels |
| pin_oe | output | 3 | Per-line output enable |
| pin_out | output | 3 | Per-line driven level |
| drive_chg | output | 3 | One-cycle pulse per line whose drive changed |

## Verification
The bench builds the block with its default parameters: three lines, an 8-bit bus and a direction mask of 0x67. With these values, the cross of direction, latch and pin levels has only 512 points, and the bench visits every one of them at the ports. It also writes all 256 direction bytes and checks the masked readback. It walks every old and new latch value under each of the eight direction settings, and every pair of direction values, which covers every change-pulse case.

// File: rtl/gpio3_port.sv
module gpio3_port #(
  parameter int NUM_LINES = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter logic [DATA_W-1:0] DIR_MASK  = 8'h67,
  parameter logic [DATA_W-1:0] DIR_RESET = 8'h07,
  parameter logic [ADDR_W-1:0] ADDR_DIR  = 2'd0,
  parameter logic [ADDR_W-1:0] ADDR_IN   = 2'd1,
  parameter logic [ADDR_W-1:0] ADDR_OUT  = 2'd2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] drive_chg
);

  localparam int N = NUM_LINES;

  logic [DATA_W-1:0] dir_q;
  logic [N-1:0]      out_q, sync1_q, samp_q, chg_q, chg_nxt, line_in;
  logic              wr_dir, wr_out;

  assign wr_dir  = bus_wr && (bus_addr == ADDR_DIR);
  assign wr_out  = bus_wr && (bus_addr == ADDR_OUT);
  assign line_in = dir_q[N-1:0];

  always_comb begin
    chg_nxt = '0;
    if (wr_dir) chg_nxt = (bus_wdata[N-1:0] & DIR_MASK[N-1:0]) ^ line_in;
    if (wr_out) chg_nxt = (bus_wdata[N-1:0] ^ out_q) & ~line_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_RESET;
      out_q   <= '0;
      sync1_q <= '0;
      samp_q  <= '0;
      chg_q   <= '0;
    end else begin
      sync1_q <= pin_in;
      samp_q  <= sync1_q;
      chg_q   <= chg_nxt;
      if (wr_dir) dir_q <= bus_wdata & DIR_MASK;
      if (wr_out) out_q <= bus_wdata[N-1:0];
    end
  end

  assign pin_oe    = ~line_in;
  assign pin_out   = out_q;
  assign drive_chg = chg_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_DIR)      bus_rdata = dir_q;
    else if (bus_addr == ADDR_IN)  bus_rdata = DATA_W'(samp_q | (~line_in & out_q));
    else if (bus_addr == ADDR_OUT) bus_rdata = DATA_W'(out_q);
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == ($past(bus_wdata) & DIR_MASK));

  p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> out_q == $past(bus_wdata[N-1:0]));

  p_sync_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> samp_q == $past(sync1_q));

  p_no_chg_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> drive_chg == '0);

  p_chg_on_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && |((bus_wdata[N-1:0] ^ out_q) & ~line_in)) |=> |drive_chg);

  p_hold_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_dir && !wr_out) |=> ($stable(dir_q) && $stable(out_q)));

endmodule

// File: tb/gpio3_port_tb.sv
module gpio3_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] pin_in = 3'd0;
  logic [2:0] pin_oe, pin_out, drive_chg;
  logic [2:0] last_chg;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio3_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .drive_chg(drive_chg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    last_chg = drive_chg;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [2:0] p);
    pin_in = p;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 dir reset", v, 8'h07);
    rd(2'd2, v); chk("R1 latch reset", v, 8'h00);
    chk("R1 oe reset", {5'd0, pin_oe}, 8'h00);
    chk("R1 pin_out reset", {5'd0, pin_out}, 8'h00);
    chk("R1 chg reset", {5'd0, drive_chg}, 8'h00);

    // R2: every direction byte
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, 8'(d));
      rd(2'd0, v); chk("R2 dir mask", v, 8'(d) & 8'h67);
    end

    // R3: latch keeps bits 2:0
    for (int d = 0; d < 256; d += 7) begin
      wr(2'd2, 8'(d));
      rd(2'd2, v); chk("R3 latch bits", v, 8'(d) & 8'h07);
    end

    // R4, R5, R7: full cross of dir, latch, pins
    for (int d = 0; d < 8; d++) begin
      wr(2'd0, 8'(d));
      for (int o = 0; o < 8; o++) begin
        wr(2'd2, 8'(o));
        chk("R4 oe", {5'd0, pin_oe}, 8'(~d & 7));
        chk("R4 pin_out", {5'd0, pin_out}, 8'(o));
        for (int p = 0; p < 8; p++) begin
          set_pins(3'(p));
          chk("R7 no chg on input", {5'd0, drive_chg}, 8'h00);
          rd(2'd1, v);
          chk("R5 input merge", v, 8'((p | (~d & o)) & 7));
        end
      end
    end

    // R6: two-edge latency with all lines inputs, latch clear
    wr(2'd0, 8'h07); wr(2'd2, 8'h00);
    set_pins(3'd0);
    pin_in = 3'b101;
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R6 not after one edge", v, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); chk("R6 after two edges", v, 8'h05);

    // R8: latch change pulses
    for (int d = 0; d < 8; d++) begin
      wr(2'd0, 8'(d));
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          wr(2'd2, 8'(a));
          wr(2'd2, 8'(b));
          chk("R8 latch chg", {5'd0, last_chg}, 8'((a ^ b) & ~d & 7));
        end
    end

    // R9: direction change pulses
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        wr(2'd0, 8'(a));
        wr(2'd0, 8'(b));
        chk("R9 dir chg", {5'd0, last_chg}, 8'((a ^ b) & 7));
      end

    // R10: writes to input and spare address ignored
    wr(2'd0, 8'h05); wr(2'd2, 8'h02);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); chk("R10 dir after addr1 write", v, 8'h05);
    rd(2'd2, v); chk("R10 latch after addr1 write", v, 8'h02);
    wr(2'd3, 8'hFF);
    rd(2'd0, v); chk("R10 dir after addr3 write", v, 8'h05);
    rd(2'd2, v); chk("R10 latch after addr3 write", v, 8'h02);
    rd(2'd3, v); chk("R10 addr3 reads zero", v, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule